// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches translations from virtual page number to physical frame number for a single address space. A lookup compares the requested page against every entry at once and answers hit and frame in the same cycle. On a miss the page-table walker, which is outside this block, installs the pair through the refill port.

Entries keep no referenced bit, because an entry is only present if its page was used. When a valid entry is evicted, its page, frame and dirty bit go out on a one-cycle write-back strobe. That strobe always marks the page as referenced, so the in-memory table can be updated. A flush empties the buffer and sends nothing back.

Top module: `tlb`

## Requirements
- R1: When `lk_valid` is high and a valid entry holds `lk_vpn`, `lk_hit` is 1 and `lk_pfn` carries that entry's frame in the same cycle.
- R2: When `lk_valid` is low or no valid entry holds `lk_vpn`, `lk_hit` is 0 and `lk_pfn` is 0.
- R3: A refill (`fill_valid` high, `flush` low) at one clock edge makes its page hit with its frame from the next cycle on.
- R4: A refill takes the lowest-numbered invalid entry while any entry is invalid.
- R5: When all entries are valid, a refill replaces the entry at a round-robin pointer. The pointer starts at 0 after reset, steps by one per such refill, wraps from ENTRIES-1 to 0, and is not moved by a flush.
- R6: A refill that replaces a valid entry raises `wb_valid` for exactly the next cycle, with `wb_vpn` and `wb_pfn` of the replaced entry. A refill into an invalid entry raises no strobe.
- R7: `wb_ref` is 1 in every cycle in which `wb_valid` is 1, and 0 otherwise.
- R8: A lookup hit with `lk_store` high sets the entry's dirty bit. A refill clears it. `wb_dirty` reports the victim's dirty bit, including a store hit to it in the refill cycle.
- R9: `flush` invalidates every entry at the clock edge, raises no write-back, and a refill in the same cycle is dropped.
- R10: After reset no entry is valid and `wb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_store | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame of the hit entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page to install |
| fill_pfn | input | PFN_W | Frame to install |
| wb_valid | output | 1 | Write-back strobe for the evicted entry |
| wb_vpn | output | VPN_W | Evicted page |
| wb_pfn | output | PFN_W | Evicted frame |
| wb_dirty | output | 1 | Evicted entry was written |
| wb_ref | output | 1 | Referenced flag for the page table |

## Verification
The checks assume that the walker never installs a page that is already present, so no two valid entries share a page. The bench model refuses any refill whose page it already holds. The checks also assume that the refill and flush inputs carry no meaning while reset is asserted, and the bench holds them low then. The stimulus fills the table to capacity, wraps the round-robin pointer, combines store hits with refills of the same entry, and flushes while a refill is pending.

// File: rtl/tlb.sv
module tlb #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 10,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  output logic             wb_valid,
  output logic [VPN_W-1:0] wb_vpn,
  output logic [PFN_W-1:0] wb_pfn,
  output logic             wb_dirty,
  output logic             wb_ref
);
  logic [ENTRIES-1:0] ent_v, ent_d, match;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr, free_idx, victim;
  logic               any_free;
  logic               store_hit;
  logic               do_fill;

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = lk_valid && ent_v[i] && (ent_vpn[i] == lk_vpn);
      if (match[i]) lk_pfn = lk_pfn | ent_pfn[i];
    end
  end
  assign lk_hit    = |match;
  assign store_hit = lk_hit && lk_store;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (!ent_v[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
  end
  assign victim  = any_free ? free_idx : rr_ptr;
  assign do_fill = fill_valid && !flush;
  assign wb_ref  = wb_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v    <= '0;
      ent_d    <= '0;
      rr_ptr   <= '0;
      wb_valid <= 1'b0;
      wb_vpn   <= '0;
      wb_pfn   <= '0;
      wb_dirty <= 1'b0;
    end else if (flush) begin
      ent_v    <= '0;
      ent_d    <= '0;
      wb_valid <= 1'b0;
    end else begin
      wb_valid <= 1'b0;
      if (store_hit) ent_d <= ent_d | match;
      if (do_fill) begin
        if (!any_free)
          rr_ptr <= (rr_ptr == IDX_W'(ENTRIES-1)) ? '0 : rr_ptr + 1'b1;
        if (ent_v[victim]) begin
          wb_valid <= 1'b1;
          wb_vpn   <= ent_vpn[victim];
          wb_pfn   <= ent_pfn[victim];
          wb_dirty <= ent_d[victim] | (store_hit & match[victim]);
        end
        ent_v[victim] <= 1'b1;
        ent_d[victim] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill && rst_n) begin
      ent_vpn[victim] <= fill_vpn;
      ent_pfn[victim] <= fill_pfn;
    end
  end
endmodule

module tlb_checker #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 10,
  parameter int PFN_W   = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_store,
  input logic             lk_hit,
  input logic [PFN_W-1:0] lk_pfn,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PFN_W-1:0] fill_pfn,
  input logic             wb_valid,
  input logic [VPN_W-1:0] wb_vpn,
  input logic [PFN_W-1:0] wb_pfn,
  input logic             wb_dirty,
  input logic             wb_ref
);
  assert_idle_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && lk_pfn == '0));

  assert_fill_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fill_valid && !flush) && lk_valid && lk_vpn == $past(fill_vpn))
      |-> (lk_hit && lk_pfn == $past(fill_pfn)));

  assert_wb_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($past(rst_n) && $past(fill_valid) && !$past(flush)));

  assert_wb_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ref == wb_valid);

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(flush)) |-> (!wb_valid && !lk_hit));
endmodule

bind tlb tlb_checker #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (.*);

// File: tb/sim_tlb.sv
module sim_tlb;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, lk_valid = 0, lk_store = 0, fill_valid = 0;
  logic [9:0] lk_vpn = '0, fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic lk_hit, wb_valid, wb_dirty, wb_ref;
  logic [19:0] lk_pfn, wb_pfn;
  logic [9:0] wb_vpn;

  tlb u0 (.*);
  always #4 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;
  bit mv[N], md[N];
  int mvpn[N], mpfn[N];
  int ptr = 0;
  bit e_wbv = 0, e_wbd = 0;
  int e_wbvpn = 0, e_wbpfn = 0;

  task automatic cmp(string tag, string what, int got, int exp);
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  function automatic int find(int v);
    for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == v) return i;
    return -1;
  endfunction

  task automatic step(bit lv, int lvp, bit ls, bit fv, int fvp, int fpf, bit fl, string tag);
    int h, vic;
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvp[9:0]; lk_store = ls;
    fill_valid = fv; fill_vpn = fvp[9:0]; fill_pfn = fpf[19:0]; flush = fl;
    #2;
    h = lv ? find(lvp) : -1;
    vectors++;
    cmp(tag, "lk_hit", int'(lk_hit), (h >= 0) ? 1 : 0);
    cmp(tag, "lk_pfn", int'(lk_pfn), (h >= 0) ? mpfn[h] : 0);
    cmp(tag, "wb_valid", int'(wb_valid), int'(e_wbv));
    cmp(tag, "wb_ref R7", int'(wb_ref), int'(e_wbv));
    if (e_wbv) begin
      cmp(tag, "wb_vpn", int'(wb_vpn), e_wbvpn);
      cmp(tag, "wb_pfn", int'(wb_pfn), e_wbpfn);
      cmp(tag, "wb_dirty R8", int'(wb_dirty), int'(e_wbd));
    end
    @(posedge clk);
    e_wbv = 0;
    if (fl) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; md[i] = 0; end
    end else begin
      if (h >= 0 && ls) md[h] = 1;
      if (fv) begin
        vic = -1;
        for (int i = N-1; i >= 0; i--) if (!mv[i]) vic = i;
        if (vic < 0) begin vic = ptr; ptr = (ptr + 1) % N; end
        if (mv[vic]) begin
          e_wbv = 1; e_wbvpn = mvpn[vic]; e_wbpfn = mpfn[vic]; e_wbd = md[vic];
        end
        mv[vic] = 1; md[vic] = 0; mvpn[vic] = fvp; mpfn[vic] = fpf;
      end
    end
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    for (int i = 0; i < N; i++) begin mv[i] = 0; md[i] = 0; mvpn[i] = 0; mpfn[i] = 0; end
    #20; rst_n = 1;
    step(1, 5, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < N; i++)
      step(i > 0, i - 1, 0, 1, i, i * 3 + 7, 0, "R3");
    step(1, 31, 0, 0, 0, 0, 0, "R1");
    step(0, 31, 0, 0, 0, 0, 0, "R2");
    step(1, 3, 1, 0, 0, 0, 0, "R8");
    step(1, 1, 1, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 6; i++)
      step(1, 200, 0, 1, 100 + i, 500 + i, 0, "R5");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 100, 0, 0, 0, 0, 0, "R4");
    step(1, 6, 1, 1, 106, 506, 0, "R8");
    idle("R6");
    step(1, 7, 0, 1, 300, 900, 1, "R9");
    step(1, 7, 0, 0, 0, 0, 0, "R9");
    step(1, 300, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < N; i++)
      step(1, 400 + i, 0, 1, 400 + i, 1000 + i, 0, "R6");
    for (int i = 0; i < 40; i++)
      step(1, 400 + i, i % 3 == 0, 1, 600 + i, 2000 + i, 0, "R5");
    for (int k = 0; k < 600; k++) begin
      int lv, fv, fp, fl;
      seed = seed * 1103515245 + 12345;
      lv = (seed >>> 8) & 63;
      fv = (seed >>> 16) & 63;
      fp = (seed >>> 4) & 1023;
      fl = ((seed >>> 24) & 63) == 0;
      step(1, lv, ((seed >>> 14) & 1) == 1, find(fv) < 0 && ((seed >>> 15) & 1) == 1,
           fv, fp, fl, "R1");
    end
    idle("R6");
    idle("R6");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule